// File: doc/BRIEF.md
# Temperature-Aware Victim Selector for a Set-Associative Cache

This block chooses which way of a cache set should be replaced, with the DRAM temperature in view. Each line in the cache carries one bit. That bit is the highest bit of the line's bank/rank address, and it tells which of two paired DRAM ranks the line came from. A boot-time configuration input states which value of that bit marks the hot rank. For every set the block keeps a full least-recently-used ordering of the ways. When it picks a victim, it looks only at a window of the least recent positions, whose depth is a parameter. Inside that window it evicts lines from the cool rank before lines from the hot rank. Hot-rank data therefore stays in the cache longer, and traffic moves away from the chips that run warmer.

The cache controller reports every hit and every fill to the block: the set, the way and, on a fill, the rank bit of the new line. It asks for a victim by presenting a set index. The victim is formed combinationally in the same cycle and comes from the stored state as it was before any update in that cycle. The tag store, the data arrays and the DRAM controller sit outside this block.

Top module: `tlru_victim_sel`

## Requirements
- R1: After reset, every set is ordered with way 0 most recent up to way WAYS-1 least recent, and every way records rank bit 0.
- R2: A hit or a fill on way w of set s makes w the most recent way of s. Each way that was more recent than w moves one position older. Ways that were older than w keep their positions.
- R3: A fill stores upd_rank as the rank bit of the filled way. A hit leaves the stored rank bit of that way unchanged.
- R4: A line counts as hot when its stored rank bit equals cfg_hot_rank, and as cool otherwise.
- R5: Only the WIN least recent positions of the queried set are candidates. A cool line in any more recent position has no effect on the victim.
- R6: If the window holds at least one cool line, the victim is the cool line in the least recent position of the window.
- R7: If every line in the window is hot, the victim is the way in the least recent position.
- R8: victim_way is valid in the same cycle as qry_set and shows the state before any update in that cycle. An update becomes visible in the following cycle.
- R9: An update to one set leaves the order and rank bits of every other set unchanged.
- R10: With WIN = 1 the victim is always the least recent way, whatever the rank bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hot_rank | input | 1 | Rank-bit value that marks the hot rank, set at boot |
| upd_valid | input | 1 | Record a hit or fill this cycle |
| upd_fill | input | 1 | 1 = fill (store rank bit), 0 = hit |
| upd_set | input | $clog2(SETS) | Set of the hit or fill |
| upd_way | input | $clog2(WAYS) | Way of the hit or fill |
| upd_rank | input | 1 | Rank bit of the filled line |
| qry_set | input | $clog2(SETS) | Set whose victim is requested |
| victim_way | output | $clog2(WAYS) | Selected victim way |

## Verification
The assertions assume that cfg_hot_rank stays constant while the cache runs. They also assume that upd_way is always below WAYS, so that every stored order remains a permutation of the way indices. The bench changes the configuration bit only while no update is in flight. It draws every way index from the legal range and keeps a reference model of order and rank bits that is driven from the same calls. Queries aimed at the set being updated in the same cycle are checked against the state before the update.

// File: rtl/tlru_pkg.sv
package tlru_pkg;
  localparam int unsigned DEF_WAYS = 8;
  localparam int unsigned DEF_WIN  = 3;
  localparam int unsigned DEF_SETS = 16;

  typedef enum logic {
    ACC_HIT  = 1'b0,
    ACC_FILL = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/tlru_order_shift.sv
// Moves one way to the most-recent slot of a flattened recency list.
module tlru_order_shift #(
  parameter int unsigned WAYS = 8,
  localparam int unsigned WW  = $clog2(WAYS)
) (
  input  logic [WAYS*WW-1:0] ord_in,
  input  logic [WW-1:0]      acc_way,
  output logic [WAYS*WW-1:0] ord_out
);
  logic [WAYS-1:0] at_or_older;

  always_comb begin
    at_or_older = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (i == WAYS - 1)
        at_or_older[i] = (ord_in[i*WW +: WW] == acc_way);
      else
        at_or_older[i] = at_or_older[i+1] | (ord_in[i*WW +: WW] == acc_way);
    end
  end

  always_comb begin
    ord_out[WW-1:0] = acc_way;
    for (int i = 1; i < WAYS; i++) begin
      ord_out[i*WW +: WW] = at_or_older[i] ? ord_in[(i-1)*WW +: WW]
                                           : ord_in[i*WW +: WW];
    end
  end
endmodule

// File: rtl/tlru_window_pick.sv
// Chooses the victim among the WIN least recent positions.
module tlru_window_pick #(
  parameter int unsigned WAYS = 8,
  parameter int unsigned WIN  = 3,
  localparam int unsigned WW  = $clog2(WAYS)
) (
  input  logic [WAYS*WW-1:0] ord_in,
  input  logic [WAYS-1:0]    rank_in,
  input  logic               hot_rank,
  output logic [WW-1:0]      victim
);
  logic [WW-1:0] slot_way;

  always_comb begin
    victim = ord_in[(WAYS-1)*WW +: WW];
    for (int i = WAYS - WIN; i < WAYS; i++) begin
      slot_way = ord_in[i*WW +: WW];
      if (rank_in[slot_way] != hot_rank)
        victim = slot_way;
    end
  end
endmodule

// File: rtl/tlru_victim_sel.sv
module tlru_victim_sel #(
  parameter int unsigned WAYS = tlru_pkg::DEF_WAYS,
  parameter int unsigned WIN  = tlru_pkg::DEF_WIN,
  parameter int unsigned SETS = tlru_pkg::DEF_SETS,
  localparam int unsigned WW  = $clog2(WAYS),
  localparam int unsigned SW  = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_hot_rank,
  input  logic          upd_valid,
  input  logic          upd_fill,
  input  logic [SW-1:0] upd_set,
  input  logic [WW-1:0] upd_way,
  input  logic          upd_rank,
  input  logic [SW-1:0] qry_set,
  output logic [WW-1:0] victim_way
);
  import tlru_pkg::*;

  logic [WAYS*WW-1:0] ord_q  [SETS];
  logic [WAYS-1:0]    rank_q [SETS];

  logic [WAYS*WW-1:0] ord_upd_cur, ord_upd_nxt, ord_rd;
  logic [WAYS-1:0]    rank_rd;
  acc_kind_e          acc_kind;

  assign acc_kind    = acc_kind_e'(upd_fill);
  assign ord_upd_cur = ord_q[upd_set];
  assign ord_rd      = ord_q[qry_set];
  assign rank_rd     = rank_q[qry_set];

  tlru_order_shift #(.WAYS(WAYS)) u_shift (
    .ord_in  (ord_upd_cur),
    .acc_way (upd_way),
    .ord_out (ord_upd_nxt)
  );

  tlru_window_pick #(.WAYS(WAYS), .WIN(WIN)) u_pick (
    .ord_in   (ord_rd),
    .rank_in  (rank_rd),
    .hot_rank (cfg_hot_rank),
    .victim   (victim_way)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        for (int i = 0; i < WAYS; i++)
          ord_q[s][i*WW +: WW] <= WW'(i);
        rank_q[s] <= '0;
      end
    end else if (upd_valid) begin
      ord_q[upd_set] <= ord_upd_nxt;
      if (acc_kind == ACC_FILL)
        rank_q[upd_set][upd_way] <= upd_rank;
    end
  end

  // ---------------- assertions ----------------
  logic [WAYS-1:0] present_ways;
  int unsigned     win_cool_cnt;
  logic            victim_in_win;

  always_comb begin
    present_ways  = '0;
    win_cool_cnt  = 0;
    victim_in_win = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      present_ways[ord_rd[i*WW +: WW]] = 1'b1;
      if (i >= int'(WAYS - WIN)) begin
        if (rank_rd[ord_rd[i*WW +: WW]] != cfg_hot_rank)
          win_cool_cnt = win_cool_cnt + 1;
        if (ord_rd[i*WW +: WW] == victim_way)
          victim_in_win = 1'b1;
      end
    end
  end

  assert_mru_on_update_R2: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> ord_q[$past(upd_set)][WW-1:0] == $past(upd_way));

  assert_order_is_perm_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(present_ways) == WAYS);

  assert_fill_rank_R3: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_fill) |=> rank_q[$past(upd_set)][$past(upd_way)] == $past(upd_rank));

  assert_victim_in_window_R5: assert property (@(posedge clk) disable iff (rst)
    victim_in_win);

  assert_cool_first_R6: assert property (@(posedge clk) disable iff (rst)
    (win_cool_cnt != 0) |-> (rank_rd[victim_way] != cfg_hot_rank));

  assert_all_hot_lru_R7: assert property (@(posedge clk) disable iff (rst)
    (win_cool_cnt == 0) |-> (victim_way == ord_rd[(WAYS-1)*WW +: WW]));
endmodule

// File: tb/tlru_victim_sel_test.sv
module tlru_victim_sel_test;
  localparam int WAYS = 8;
  localparam int WIN  = 3;
  localparam int SETS = 16;
  localparam int WW   = $clog2(WAYS);
  localparam int SW   = $clog2(SETS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_hot_rank = 1'b0;
  logic upd_valid = 1'b0, upd_fill = 1'b0, upd_rank = 1'b0;
  logic [SW-1:0] upd_set = '0, qry_set = '0;
  logic [WW-1:0] upd_way = '0;
  logic [WW-1:0] victim_a, victim_b;

  always #10 clk = ~clk;

  tlru_victim_sel #(.WAYS(WAYS), .WIN(WIN), .SETS(SETS)) uut (
    .clk(clk), .rst(rst), .cfg_hot_rank(cfg_hot_rank),
    .upd_valid(upd_valid), .upd_fill(upd_fill), .upd_set(upd_set),
    .upd_way(upd_way), .upd_rank(upd_rank), .qry_set(qry_set),
    .victim_way(victim_a));

  tlru_victim_sel #(.WAYS(WAYS), .WIN(1), .SETS(SETS)) uut_lru (
    .clk(clk), .rst(rst), .cfg_hot_rank(cfg_hot_rank),
    .upd_valid(upd_valid), .upd_fill(upd_fill), .upd_set(upd_set),
    .upd_way(upd_way), .upd_rank(upd_rank), .qry_set(qry_set),
    .victim_way(victim_b));

  typedef struct {
    int    exp_a;
    int    exp_b;
    string req;
  } sb_item_t;

  sb_item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  int ref_ord [SETS][WAYS];
  bit ref_rank[SETS][WAYS];

  function automatic int exp_victim(int s, int win);
    for (int i = WAYS - 1; i >= WAYS - win; i--)
      if (ref_rank[s][ref_ord[s][i]] != cfg_hot_rank) return ref_ord[s][i];
    return ref_ord[s][WAYS-1];
  endfunction

  task automatic model_reset();
    for (int s = 0; s < SETS; s++)
      for (int i = 0; i < WAYS; i++) begin
        ref_ord[s][i]  = i;
        ref_rank[s][i] = 1'b0;
      end
  endtask

  task automatic model_touch(int s, int w, bit fill, bit r);
    int p;
    p = 0;
    for (int i = 0; i < WAYS; i++) if (ref_ord[s][i] == w) p = i;
    for (int i = WAYS - 1; i > 0; i--) if (i <= p) ref_ord[s][i] = ref_ord[s][i-1];
    ref_ord[s][0] = w;
    if (fill) ref_rank[s][w] = r;
  endtask

  // driver: one cycle of stimulus, expected victims pushed before the update
  task automatic step(bit uv, bit fill, int us, int uw, bit ur, int qs, string req);
    sb_item_t it;
    @(negedge clk);
    #1;
    upd_valid = uv; upd_fill = fill; upd_set = SW'(us);
    upd_way = WW'(uw); upd_rank = ur; qry_set = SW'(qs);
    it.exp_a = exp_victim(qs, WIN);
    it.exp_b = exp_victim(qs, 1);
    it.req   = req;
    sb_q.push_back(it);
    if (uv) model_touch(us, uw, fill, ur);
  endtask

  // monitor: samples away from the active edge
  initial begin
    sb_item_t it;
    forever begin
      @(negedge clk);
      #5;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        checks++;
        if (int'(victim_a) != it.exp_a) begin
          errors++;
          $display("FAIL %s victim actual %0d expected %0d", it.req, victim_a, it.exp_a);
        end
        checks++;
        if (int'(victim_b) != it.exp_b) begin
          errors++;
          $display("FAIL R10 window-1 victim actual %0d expected %0d", victim_b, it.exp_b);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lfsr;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state: all hot, LRU is the last way
    step(0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 5, "R1");
    // R4 flip the hot value: all lines now cool
    @(negedge clk); cfg_hot_rank = 1'b1;
    step(0, 0, 0, 0, 0, 0, "R4");
    @(negedge clk); cfg_hot_rank = 1'b0;
    step(0, 0, 0, 0, 0, 0, "R4");
    // R8 query the set being filled in the same cycle: pre-update state
    step(1, 1, 0, 7, 1, 0, "R8");
    step(0, 0, 0, 0, 0, 0, "R2/R7");
    // R5 cool line outside the window is ignored
    step(1, 1, 0, 3, 1, 0, "R8");
    step(0, 0, 0, 0, 0, 0, "R5");
    // R2 hits shift ways; R3 hit with rank 0 keeps way 3 cool
    step(1, 0, 0, 4, 0, 0, "R2");
    step(1, 0, 0, 3, 0, 0, "R3");
    step(1, 0, 0, 6, 0, 0, "R2");
    step(1, 0, 0, 5, 0, 0, "R2");
    step(1, 0, 0, 4, 0, 0, "R2");
    step(1, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 1, 0, 0, "R2");
    step(1, 0, 0, 2, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, "R6");
    step(1, 0, 0, 7, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, "R3/R6");
    // R9 other sets untouched
    step(0, 0, 0, 0, 0, 1, "R9");
    step(0, 0, 0, 0, 0, 15, "R9");

    // mixed traffic across a few sets
    lfsr = 32'h1ace;
    for (int n = 0; n < 600; n++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      step(lfsr[0], lfsr[1], (lfsr >> 2) & 3, (lfsr >> 4) & 7, lfsr[7],
           (lfsr >> 8) & 3, "R5/R6/R7/R9");
    end
    step(0, 0, 0, 0, 0, 0, "R6");
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule